// File: doc/BRIEF.md
# Multiplexed-Bus ROM/DRAM Controller

This block serves cycles from a processor whose 32-bit bus carries the address and the data on the same wires. When the address-valid strobe is high, the block captures the word address from bus bits 31:4 and four byte enables from bits 3:0. Bits 3:2 of the word address come from a separate pair of lines. The block decodes the captured address into one of three ROM banks, one of three DRAM banks, or no device. It then runs the timing sequence for that device.

For DRAM it presents the row on an 11-bit multiplexed address with the bank's row strobe. It then presents the column with per-byte column strobes. For ROM it asserts the bank select and a shared output enable for a fixed wait. Read data returns on the bus with an active-low data-valid strobe. Every cycle ends with a single active-low acknowledge. A read can ask for a four-word burst, which walks the word offsets upward from the starting word and wraps within the four-word line.

The memory devices sit outside the block. The block drives their strobes and address and samples their data on `mem_rdata` in the last wait cycle before each beat.

Top module: `membus_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every active-low strobe is high (ras_n, cas_n, rom_cs_n, rom_oe_n, dram_we_n, ack_n, rdce_n) and ad_oe is low.
- R2: The decode works on the byte address {ad_in[31:4], word_lo, 2'b00}. 0x1FC00000..0x1FFFFFFF selects rom_cs_n[2] (boot), 0x1F800000..0x1FBFFFFF selects rom_cs_n[1], 0x1F400000..0x1F7FFFFF selects rom_cs_n[0], and DRAM bank b (ras_n[b]) covers b*0x400000 up to (b+1)*0x400000-1 for b = 0..2. At most one row strobe is low, and no row strobe is low at the same time as a ROM select.
- R3: An access starts only on a cycle with ale high while the block is idle and rd_n or wr_n is low (rd_n low means read). ad_in[3:0] are active-high byte enables for lanes 3..0. An ale pulse during an access, or with both rd_n and wr_n high, is ignored.
- R4: DRAM: counting the ale cycle as cycle 0, ras_n of the bank is low from cycle 1 with dram_addr = {1'b0, addr[21:12]} and all cas_n high in cycles 1–2. In cycles 3–4, cas_n is low and dram_addr = {1'b0, addr[11:4], word}.
- R5: cas_n[i] is low in the column phase for each enabled lane i on single accesses and for all four lanes on burst reads. dram_we_n is low only in the column phase of writes.
- R6: ROM: the bank select is low from cycle 1 and rom_oe_n is low with it on reads only. Read data is valid in cycle 5 after four wait cycles.
- R7: A read with burst_n low on the ale cycle returns four beats with word offsets start, start+1, start+2, start+3 modulo 4. The beats fall in cycles 5, 8, 11 and 14 for ROM and DRAM.
- R8: burst_n is ignored on writes: a write makes one column phase on its enabled lanes and one acknowledge in cycle 5.
- R9: An address in no region drives no memory strobe. A read returns 0xFFFFFFFF in cycle 2 (bursts: cycles 2, 4, 6, 8), and a write is acknowledged in cycle 2.
- R10: rdce_n pulses low, with ad_oe high and the read word on ad_out, once per read beat and never on writes. ack_n pulses low for exactly one cycle per access, in the cycle of the last read beat or of write completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_in | input | 32 | Multiplexed bus from processor: address[31:4] and byte enables[3:0] in address phase |
| ad_out | output | 32 | Read data driven back onto the bus |
| ad_oe | output | 1 | High when ad_out carries read data |
| word_lo | input | 2 | Non-multiplexed word address bits 3:2 |
| ale | input | 1 | Address valid on ad_in (active high) |
| burst_n | input | 1 | Four-word burst request on reads (active low) |
| rd_n | input | 1 | Read cycle (active low) |
| wr_n | input | 1 | Write cycle (active low) |
| ack_n | output | 1 | Cycle acknowledge (active low) |
| rdce_n | output | 1 | Read data valid (active low) |
| rom_cs_n | output | 3 | ROM bank selects, bit 2 boot bank (active low) |
| rom_oe_n | output | 1 | Shared ROM output enable (active low) |
| dram_addr | output | 11 | Multiplexed DRAM row/column address |
| ras_n | output | 3 | DRAM row strobes per bank (active low) |
| cas_n | output | 4 | DRAM column strobes per byte lane (active low) |
| dram_we_n | output | 1 | DRAM write strobe (active low) |
| word_sel | output | 2 | Word offset of the current beat, for the ROM address |
| mem_rdata | input | 32 | Data returned by the selected memory device |

## Verification
Two things can land in the same cycle. One is the last data-valid beat of a read and the acknowledge that ends it. The other is a fresh address-valid pulse and an access still in progress. The bench checks that the acknowledge falls exactly on the last burst beat, never earlier, and that only one acknowledge appears. It also raises ale, with a different address and word offset, two cycles into DRAM and ROM accesses. The beats, data, lanes and acknowledge must then stay identical to the undisturbed access, and the next access must start cleanly.

// File: rtl/membus_pkg.sv
`timescale 1ns/1ps
package membus_pkg;

    localparam int BUS_W    = 32;
    localparam int LANES    = 4;
    localparam int COL_BITS = 10;
    localparam int DRAM_AW  = 11;
    localparam int KEEP_W   = 2 * COL_BITS - 2;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_ROM  = 2'd1,
        KIND_DRAM = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [1:0] bank;
    } target_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    typedef struct packed {
        logic [KEEP_W-1:0] line;
        logic [LANES-1:0]  be;
        logic              rd;
        logic              burst;
        target_t           tgt;
    } cycle_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/membus_decode.sv
`timescale 1ns/1ps
module membus_decode
    import membus_pkg::*;
#(
    parameter int          WIN_BITS   = 22,
    parameter int          ROM_BANKS  = 3,
    parameter int          DRAM_BANKS = 3,
    parameter logic [31:0] BOOT_BASE  = 32'h1FC0_0000
) (
    input  logic [BUS_W-WIN_BITS-1:0] win_idx,
    output target_t                   tgt
);
    localparam int IDX_W = BUS_W - WIN_BITS;
    localparam logic [IDX_W-1:0] BOOT_IDX = BOOT_BASE[BUS_W-1:WIN_BITS];

    // DRAM windows count up from zero; ROM windows count down from the boot window,
    // the boot window taking the highest bank number.
    always_comb begin
        tgt = '{KIND_NONE, 2'd0};
        for (int b = 0; b < DRAM_BANKS; b++) begin
            if (win_idx == IDX_W'(b)) begin
                tgt.kind = KIND_DRAM;
                tgt.bank = 2'(b);
            end
        end
        for (int b = 0; b < ROM_BANKS; b++) begin
            if (win_idx == BOOT_IDX - IDX_W'(ROM_BANKS - 1 - b)) begin
                tgt.kind = KIND_ROM;
                tgt.bank = 2'(b);
            end
        end
    end
endmodule

// File: rtl/membus_seq.sv
`timescale 1ns/1ps
module membus_seq
    import membus_pkg::*;
#(
    parameter int ROW_CYC   = 2,
    parameter int COL_CYC   = 2,
    parameter int ROM_LEAD  = 4,
    parameter int ROM_GAP   = 2,
    parameter int NONE_CYC  = 1,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              burst_n,
    input  logic [KEEP_W-1:0] line_in,
    input  logic [LANES-1:0]  be_in,
    input  logic [1:0]        word_lo,
    input  target_t           tgt_in,
    input  logic [BUS_W-1:0]  mem_rdata,
    output phase_e            phase,
    output cycle_t            cyc,
    output logic [1:0]        word_cur,
    output logic              last_beat,
    output logic [BUS_W-1:0]  rdata_q
);
    localparam int MAXC   = max2(max2(ROW_CYC, COL_CYC), max2(max2(ROM_LEAD, ROM_GAP), NONE_CYC));
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    logic [CNT_W-1:0]  cnt;
    logic [BEAT_W-1:0] beat;
    logic [CNT_W-1:0]  gap_cnt;

    assign last_beat = !cyc.burst || (beat == BEAT_W'(BURST_LEN - 1));

    always_comb begin
        case (cyc.tgt.kind)
            KIND_DRAM: gap_cnt = CNT_W'(COL_CYC - 1);
            KIND_ROM:  gap_cnt = CNT_W'(ROM_GAP - 1);
            default:   gap_cnt = CNT_W'(NONE_CYC - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cyc      <= '0;
            word_cur <= '0;
            beat     <= '0;
            cnt      <= '0;
            rdata_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (ale && (!rd_n || !wr_n)) begin
                        cyc.line  <= line_in;
                        cyc.be    <= be_in;
                        cyc.rd    <= !rd_n;
                        cyc.burst <= !rd_n && !burst_n;
                        cyc.tgt   <= tgt_in;
                        word_cur  <= word_lo;
                        beat      <= '0;
                        case (tgt_in.kind)
                            KIND_DRAM: begin
                                phase <= PH_ROW;
                                cnt   <= CNT_W'(ROW_CYC - 1);
                            end
                            KIND_ROM: begin
                                phase <= PH_WAIT;
                                cnt   <= CNT_W'(ROM_LEAD - 1);
                            end
                            default: begin
                                phase <= PH_WAIT;
                                cnt   <= CNT_W'(NONE_CYC - 1);
                            end
                        endcase
                    end
                end
                PH_ROW: begin
                    if (cnt == '0) begin
                        phase <= PH_WAIT;
                        cnt   <= CNT_W'(COL_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (cnt == '0) begin
                        phase   <= PH_DATA;
                        rdata_q <= (cyc.tgt.kind == KIND_NONE) ? '1 : mem_rdata;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (last_beat) begin
                        phase <= PH_IDLE;
                    end else begin
                        phase    <= PH_WAIT;
                        beat     <= beat + 1'b1;
                        word_cur <= word_cur + 2'd1;
                        cnt      <= gap_cnt;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/membus_pins.sv
`timescale 1ns/1ps
module membus_pins
    import membus_pkg::*;
#(
    parameter int ROM_BANKS  = 3,
    parameter int DRAM_BANKS = 3
) (
    input  phase_e                phase,
    input  cycle_t                cyc,
    input  logic [1:0]            word_cur,
    input  logic                  last_beat,
    input  logic [BUS_W-1:0]      rdata_q,
    output logic [BUS_W-1:0]      ad_out,
    output logic                  ad_oe,
    output logic                  ack_n,
    output logic                  rdce_n,
    output logic [ROM_BANKS-1:0]  rom_cs_n,
    output logic                  rom_oe_n,
    output logic [DRAM_AW-1:0]    dram_addr,
    output logic [DRAM_BANKS-1:0] ras_n,
    output logic [LANES-1:0]      cas_n,
    output logic                  dram_we_n,
    output logic [1:0]            word_sel
);
    logic                  busy;
    logic                  dram_act;
    logic                  rom_act;
    logic                  col_phase;
    logic [2*COL_BITS-1:0] waddr;
    logic [LANES-1:0]      lanes;

    assign busy      = (phase != PH_IDLE);
    assign dram_act  = busy && (cyc.tgt.kind == KIND_DRAM);
    assign rom_act   = busy && (cyc.tgt.kind == KIND_ROM);
    assign col_phase = dram_act && (phase == PH_WAIT);
    assign waddr     = {cyc.line, word_cur};
    assign lanes     = cyc.burst ? {LANES{1'b1}} : cyc.be;

    assign dram_addr = (phase == PH_ROW) ? DRAM_AW'(waddr[2*COL_BITS-1:COL_BITS])
                                         : DRAM_AW'(waddr[COL_BITS-1:0]);
    assign cas_n     = col_phase ? ~lanes : {LANES{1'b1}};
    assign dram_we_n = !(col_phase && !cyc.rd);
    assign rom_oe_n  = !(rom_act && cyc.rd);

    for (genvar b = 0; b < DRAM_BANKS; b++) begin : g_ras
        assign ras_n[b] = !(dram_act && (cyc.tgt.bank == 2'(b)));
    end

    for (genvar b = 0; b < ROM_BANKS; b++) begin : g_rcs
        assign rom_cs_n[b] = !(rom_act && (cyc.tgt.bank == 2'(b)));
    end

    assign ad_oe    = (phase == PH_DATA) && cyc.rd;
    assign rdce_n   = !ad_oe;
    assign ad_out   = ad_oe ? rdata_q : '0;
    assign ack_n    = !((phase == PH_DATA) && last_beat);
    assign word_sel = word_cur;
endmodule

// File: rtl/membus_ctl.sv
`timescale 1ns/1ps
module membus_ctl
    import membus_pkg::*;
#(
    parameter int ROM_BANKS  = 3,
    parameter int DRAM_BANKS = 3,
    parameter int WIN_BITS   = 22
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [31:0]           ad_in,
    output logic [31:0]           ad_out,
    output logic                  ad_oe,
    input  logic [1:0]            word_lo,
    input  logic                  ale,
    input  logic                  burst_n,
    input  logic                  rd_n,
    input  logic                  wr_n,
    output logic                  ack_n,
    output logic                  rdce_n,
    output logic [ROM_BANKS-1:0]  rom_cs_n,
    output logic                  rom_oe_n,
    output logic [10:0]           dram_addr,
    output logic [DRAM_BANKS-1:0] ras_n,
    output logic [3:0]            cas_n,
    output logic                  dram_we_n,
    output logic [1:0]            word_sel,
    input  logic [31:0]           mem_rdata
);
    target_t          tgt_dec;
    phase_e           phase;
    cycle_t           cyc;
    logic [1:0]       word_cur;
    logic             last_beat;
    logic [BUS_W-1:0] rdata_q;

    membus_decode #(
        .WIN_BITS  (WIN_BITS),
        .ROM_BANKS (ROM_BANKS),
        .DRAM_BANKS(DRAM_BANKS)
    ) u_decode (
        .win_idx(ad_in[BUS_W-1:WIN_BITS]),
        .tgt    (tgt_dec)
    );

    membus_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .burst_n  (burst_n),
        .line_in  (ad_in[LANES+KEEP_W-1:LANES]),
        .be_in    (ad_in[LANES-1:0]),
        .word_lo  (word_lo),
        .tgt_in   (tgt_dec),
        .mem_rdata(mem_rdata),
        .phase    (phase),
        .cyc      (cyc),
        .word_cur (word_cur),
        .last_beat(last_beat),
        .rdata_q  (rdata_q)
    );

    membus_pins #(
        .ROM_BANKS (ROM_BANKS),
        .DRAM_BANKS(DRAM_BANKS)
    ) u_pins (
        .phase    (phase),
        .cyc      (cyc),
        .word_cur (word_cur),
        .last_beat(last_beat),
        .rdata_q  (rdata_q),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .ack_n    (ack_n),
        .rdce_n   (rdce_n),
        .rom_cs_n (rom_cs_n),
        .rom_oe_n (rom_oe_n),
        .dram_addr(dram_addr),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .dram_we_n(dram_we_n),
        .word_sel (word_sel)
    );
endmodule

// File: rtl/membus_ctl_chk.sv
`timescale 1ns/1ps
module membus_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ack_n,
    input logic       rdce_n,
    input logic       ad_oe,
    input logic [2:0] rom_cs_n,
    input logic       rom_oe_n,
    input logic [2:0] ras_n,
    input logic [3:0] cas_n,
    input logic       dram_we_n
);
    // R2
    ras_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ras_n));

    // R2
    rom_dram_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(&ras_n) |-> (&rom_cs_n));

    // R4
    row_before_col_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(&ras_n) |-> (&cas_n));

    // R4
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (rst)
        !(&cas_n) |-> !(&ras_n));

    // R5
    we_in_col_chk: assert property (@(posedge clk) disable iff (rst)
        !dram_we_n |-> !(&cas_n));

    // R6
    oe_with_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !rom_oe_n |-> !(&rom_cs_n));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_n |=> ack_n);

    // R10
    rdce_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !rdce_n |-> ad_oe);
endmodule

bind membus_ctl membus_ctl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack_n    (ack_n),
    .rdce_n   (rdce_n),
    .ad_oe    (ad_oe),
    .rom_cs_n (rom_cs_n),
    .rom_oe_n (rom_oe_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .dram_we_n(dram_we_n)
);

// File: tb/test_membus_ctl.sv
`timescale 1ns/1ps
module test_membus_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic [1:0]  word_lo = '0;
    logic        ale = 1'b0;
    logic        burst_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        ack_n;
    logic        rdce_n;
    logic [2:0]  rom_cs_n;
    logic        rom_oe_n;
    logic [10:0] dram_addr;
    logic [2:0]  ras_n;
    logic [3:0]  cas_n;
    logic        dram_we_n;
    logic [1:0]  word_sel;
    logic [31:0] mem_rdata;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] cur_addr = '0;

    always #2.5 clk = ~clk;

    membus_ctl i_membus_ctl (
        .clk(clk), .rst(rst), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .word_lo(word_lo), .ale(ale), .burst_n(burst_n), .rd_n(rd_n), .wr_n(wr_n),
        .ack_n(ack_n), .rdce_n(rdce_n), .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n),
        .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .dram_we_n(dram_we_n),
        .word_sel(word_sel), .mem_rdata(mem_rdata)
    );

    function automatic logic [1:0] bank_of(input logic [2:0] n);
        if (!n[0]) return 2'd0;
        if (!n[1]) return 2'd1;
        return 2'd2;
    endfunction

    function automatic logic [31:0] dram_val(input logic [1:0] b, input logic [10:0] r, input logic [10:0] c);
        return 32'hA500_0000 ^ ({30'd0, b} << 28) ^ ({21'd0, r} << 12) ^ {21'd0, c};
    endfunction

    function automatic logic [31:0] rom_val(input logic [1:0] b, input logic [31:0] a, input logic [1:0] w);
        return 32'h3C00_0000 ^ ({30'd0, b} << 24) ^ {4'd0, a[27:4], w, 2'b00};
    endfunction

    // returns {kind, bank}: kind 0 none, 1 ROM, 2 DRAM
    function automatic logic [3:0] classify(input logic [31:0] a);
        if (a >= 32'h1FC0_0000 && a <= 32'h1FFF_FFFF) return {2'd1, 2'd2};
        if (a >= 32'h1F80_0000 && a <= 32'h1FBF_FFFF) return {2'd1, 2'd1};
        if (a >= 32'h1F40_0000 && a <= 32'h1F7F_FFFF) return {2'd1, 2'd0};
        if (a < 32'h00C0_0000) return {2'd2, a[23:22]};
        return 4'd0;
    endfunction

    // memory stubs
    logic        prev_ras_idle = 1'b1;
    logic [10:0] row_q = '0;
    always_ff @(posedge clk) begin
        prev_ras_idle <= &ras_n;
        if (prev_ras_idle && !(&ras_n)) row_q <= dram_addr;
    end

    always_comb begin
        mem_rdata = 32'hDEAD_BEEF;
        if (!(&cas_n))
            mem_rdata = dram_val(bank_of(ras_n), row_q, dram_addr);
        else if (!(&rom_cs_n))
            mem_rdata = rom_val(bank_of(rom_cs_n), cur_addr, word_sel);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h (addr %h)", req, act, exp, cur_addr);
        end
    endtask

    task automatic access(input logic [31:0] addr, input logic [3:0] be, input bit rd,
                          input bit brst, input bit poke);
        logic [3:0]  cls;
        logic [1:0]  kind;
        logic [1:0]  bank;
        logic [1:0]  w0;
        logic [10:0] row;
        int nb, ack_k, ack_cnt, exp_nb, lead, step, last_k;
        int          beat_k[4];
        logic [31:0] beat_d[4];
        bit          stray;
        cls  = classify(addr);
        kind = cls[3:2];
        bank = cls[1:0];
        w0   = addr[3:2];
        row  = {1'b0, addr[21:12]};
        nb = 0; ack_k = -1; ack_cnt = 0; stray = 1'b0;
        exp_nb = rd ? (brst ? 4 : 1) : 0;
        lead = (kind == 2'd0) ? 2 : 5;
        step = (kind == 2'd0) ? 2 : 3;
        @(negedge clk);
        cur_addr = addr;
        ad_in    = {addr[31:4], be};
        word_lo  = w0;
        ale      = 1'b1;
        rd_n     = !rd;
        wr_n     = rd;
        burst_n  = !brst;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            if (!rdce_n) begin
                if (nb < 4) begin
                    beat_k[nb] = k;
                    beat_d[nb] = ad_out;
                end
                nb++;
            end
            if (!ack_n) begin
                ack_k = k;
                ack_cnt++;
            end
            if (kind == 2'd0 && (!(&ras_n) || !(&rom_cs_n) || !(&cas_n) || !rom_oe_n || !dram_we_n))
                stray = 1'b1;
            if (kind == 2'd2 && k == 1) begin
                chk("R2 ras_n", {29'd0, ras_n}, {29'd0, ~(3'b001 << bank)});
                chk("R4 row addr", {21'd0, dram_addr}, {21'd0, row});
                chk("R4 cas idle in row", {28'd0, cas_n}, 32'hF);
            end
            if (kind == 2'd2 && k == 3) begin
                chk("R5 cas lanes", {28'd0, cas_n}, {28'd0, (rd && brst) ? 4'h0 : ~be});
                chk("R4 col addr", {21'd0, dram_addr}, {21'd0, 1'b0, addr[11:4], w0});
                chk("R5 dram_we_n", {31'd0, dram_we_n}, {31'd0, rd});
            end
            if (kind == 2'd1 && k == 1) begin
                chk("R2 rom_cs_n", {29'd0, rom_cs_n}, {29'd0, ~(3'b001 << bank)});
                chk("R6 rom_oe_n", {31'd0, rom_oe_n}, {31'd0, !rd});
            end
            if (kind == 2'd1 && k == 4)
                chk("R6 no early data", {31'd0, rdce_n}, 32'd1);
            if (k == 1) begin
                ale   = 1'b0;
                ad_in = $urandom;
            end
            if (poke && k == 2) begin
                ale     = 1'b1;
                ad_in   = 32'h0040_0003;
                word_lo = ~w0;
            end
            if (poke && k == 3) ale = 1'b0;
        end
        rd_n = 1'b1; wr_n = 1'b1; burst_n = 1'b1;
        chk("R10 beat count", 32'(nb), 32'(exp_nb));
        for (int i = 0; i < exp_nb && i < nb; i++) begin
            logic [1:0]  w;
            logic [31:0] ed;
            w = w0 + 2'(i);
            if (kind == 2'd2)      ed = dram_val(bank, row, {1'b0, addr[11:4], w});
            else if (kind == 2'd1) ed = rom_val(bank, addr, w);
            else                   ed = 32'hFFFF_FFFF;
            chk(brst ? "R7 beat cycle" : "R6 beat cycle", 32'(beat_k[i]), 32'(lead + step * i));
            chk(kind == 2'd0 ? "R9 data" : "R7 data", beat_d[i], ed);
        end
        last_k = lead + step * ((exp_nb > 1) ? exp_nb - 1 : 0);
        chk("R10 ack count", 32'(ack_cnt), 32'd1);
        chk(rd ? "R10 ack cycle" : "R8 ack cycle", 32'(ack_k), 32'(last_k));
        if (kind == 2'd0) chk("R9 no strobes", {31'd0, stray}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        // R1: strobes idle under reset and after it
        chk("R1 strobes in reset", {20'd0, ras_n, cas_n, rom_cs_n, rom_oe_n, dram_we_n},
            {20'd0, 12'hFFF});
        rst = 1'b0;
        @(negedge clk);
        chk("R1 handshakes after reset", {29'd0, ack_n, rdce_n, ad_oe}, {29'd0, 3'b110});
        chk("R1 strobes after reset", {20'd0, ras_n, cas_n, rom_cs_n, rom_oe_n, dram_we_n},
            {20'd0, 12'hFFF});

        // R3: ale with neither strobe is ignored
        @(negedge clk);
        ad_in = 32'h0000_100F; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R3 ale without rd/wr", {28'd0, ack_n, &ras_n, &rom_cs_n, rdce_n}, 32'hF);
        end

        access(32'h0000_1230, 4'hF, 1'b1, 1'b0, 1'b0);  // DRAM 0 single read
        access(32'h0081_2348, 4'hF, 1'b1, 1'b1, 1'b0);  // DRAM 2 burst, start word 2 wraps
        access(32'h0040_567C, 4'b0101, 1'b0, 1'b0, 1'b0); // DRAM 1 write
        access(32'h0000_0A04, 4'b1000, 1'b0, 1'b1, 1'b0); // R8 write burst ignored
        access(32'h0020_0010, 4'b0010, 1'b1, 1'b0, 1'b0); // R5 single read lanes
        access(32'h1FC0_0100, 4'hF, 1'b1, 1'b0, 1'b0);  // boot ROM single read
        access(32'h1FFF_FFFC, 4'hF, 1'b1, 1'b1, 1'b0);  // boot top, burst wrap from word 3
        access(32'h1F40_0008, 4'hF, 1'b1, 1'b1, 1'b0);  // ROM 0 burst
        access(32'h1F80_0020, 4'b0011, 1'b0, 1'b0, 1'b0); // ROM 1 write
        access(32'h1FBF_FFFC, 4'hF, 1'b1, 1'b0, 1'b0);  // ROM 1 top edge
        access(32'h1F3F_FFFC, 4'hF, 1'b1, 1'b0, 1'b0);  // just below ROM 0: unmapped
        access(32'h00BF_FFFC, 4'hF, 1'b1, 1'b0, 1'b0);  // DRAM 2 top edge
        access(32'h00C0_0000, 4'hF, 1'b1, 1'b0, 1'b0);  // R9 first unmapped above DRAM
        access(32'h2000_0004, 4'hF, 1'b1, 1'b1, 1'b0);  // R9 unmapped burst
        access(32'h8000_0000, 4'h1, 1'b0, 1'b0, 1'b0);  // R9 unmapped write
        access(32'h0000_4444, 4'hF, 1'b1, 1'b1, 1'b1);  // R3 ale during DRAM burst
        access(32'h1FC0_0040, 4'hF, 1'b1, 1'b0, 1'b1);  // R3 ale during ROM read

        for (int n = 0; n < 40; n++) begin
            logic [31:0] a;
            logic [3:0]  be;
            int          sel;
            sel = $urandom % 5;
            a   = $urandom;
            case (sel)
                0: a = {8'd0, 2'($urandom % 3), a[21:0]};
                1: a = {10'h07F, a[21:0]};
                2: a = {10'h07E, a[21:0]};
                3: a = {10'h07D, a[21:0]};
                default: a = {2'b01, a[29:0]};
            endcase
            be = 4'($urandom);
            if (be == 4'h0) be = 4'h8;
            access(a, be, 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule